// File: doc/BRIEF.md
# Channel-Banked DMA Control Register File

This block is the software-facing register file of a multi-channel DMA engine. A processor reaches it over a plain 32-bit read/write bus with an 8-bit byte address. Most per-channel registers share one small window of addresses. A channel-select register decides which channel's private copy that window reaches. A port-select register does the same for a banked per-port control word. The block holds the state that software programs for each channel: on/off, direction, arbitration weight, descriptor ring base and length, interrupt enables and interrupt status.

The DMA datapath reports events to the block as pulses. Each pulse names a channel and a set of status bits, and the block latches those bits into that channel's status. The block drives the channel on and direction lines towards the datapath. It also runs a self-clearing channel reset that lasts a fixed number of cycles. It folds every channel's pending and enabled status, gated by a global per-channel enable vector, into one registered interrupt line. A write to the global control register clears the whole engine.

Top module: `dma_bank_regs`

## Requirements
- R1: The identification word at 0x08 reads the channel count in bits 31:20, the port count in bits 19:16 and the hardware revision in bits 4:0, with all other bits zero. With the default parameters it reads 0x01440003.
- R2: The channel select at 0x18 stores a channel index and reads it back. Accesses at 0x1C, 0x20, 0x24, 0x28 and 0x2C reach only the selected channel's copy, and the other channels keep their values.
- R3: The channel control word at 0x1C stores the on bit (bit 0), the transmit direction (bit 8) and the weight (bits 17:16), and reads back only those bits plus bit 1. The on bit and the direction bit of each channel appear on `ch_on` and `ch_tx`.
- R4: Writing 1 to bit 1 of 0x1C starts a channel reset. Bit 1 then reads 1 and `ch_rst` for that channel is high for exactly 4 cycles after the write edge. When the reset completes, bit 1, the on bit and that channel's status are cleared, and the direction and weight are kept. A reset request made while a reset is already running does not restart it.
- R5: The descriptor base at 0x20 and the descriptor count at 0x24 are 32-bit storage words, one pair per channel.
- R6: An event pulse sets its status bits in the status word (0x28) of the channel it names. Writing a 1 to a status bit clears it. If an event and a clear hit the same bit in the same cycle, the bit stays set. Events that name a channel in reset, or a channel index outside the channel count, are dropped.
- R7: The interrupt enable at 0x2C stores 8 bits per channel. Bit 3 is the descriptor-complete enable.
- R8: The global enable vector at 0xF4 holds one bit per channel, with bit n belonging to channel n. Bits at and above the channel count read 0.
- R9: `irq` is high one cycle after some channel has its global enable bit set and also has a status bit that is set and enabled in its own interrupt enable word.
- R10: The port select at 0x40 stores a port index and reads it back. The port control word at 0x44 is banked by that index and keeps only bits 11:8, bit 6, bits 5:4 and bits 3:2 (mask 0x00000F7C).
- R11: The polling word at 0x14 keeps only bit 31 (poll enable) and bit 6 (clock divide), so it reads back masked with 0x80000040.
- R12: Writing 1 to bit 0 of 0x10 clears all channel state, both selects, the polling word, the port words, the global enables and `irq` in the write cycle. 0x10 always reads 0. The descriptor base and count words keep their contents.
- R13: While the channel select holds an index at or above the channel count, writes to the banked channel window are ignored and reads from it return 0. Unmapped addresses also read 0.
- R14: `reg_rvalid` is high exactly one cycle after `reg_rd`, and `reg_rdata` holds the addressed value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| evt_valid | input | 1 | Datapath event pulse |
| evt_ch | input | CHW | Channel index of the event |
| evt_bits | input | ST_W | Status bits to set |
| ch_on | output | NUM_CH | Per-channel on bit |
| ch_tx | output | NUM_CH | Per-channel transmit direction |
| ch_rst | output | NUM_CH | Per-channel reset in progress |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its defaults: 20 channels, 4 ports, 8 status bits and a 4-cycle reset. With these values the 5-bit channel select can hold indices 20 to 31, which lie past the last channel, so the ignore and read-zero behaviour is reached from the bus. Channel 19, the top channel, is used for the descriptor storage that must survive an engine reset. The 2-bit port select covers every port index, so banking across ports can be checked in full.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  localparam logic [7:0] A_ID    = 8'h08;
  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_POLL  = 8'h14;
  localparam logic [7:0] A_CSEL  = 8'h18;
  localparam logic [7:0] A_CCTRL = 8'h1C;
  localparam logic [7:0] A_DBASE = 8'h20;
  localparam logic [7:0] A_DLEN  = 8'h24;
  localparam logic [7:0] A_CSTAT = 8'h28;
  localparam logic [7:0] A_CIEN  = 8'h2C;
  localparam logic [7:0] A_PSEL  = 8'h40;
  localparam logic [7:0] A_PCTRL = 8'h44;
  localparam logic [7:0] A_GIEN  = 8'hF4;

  localparam int CC_ON    = 0;
  localparam int CC_RST   = 1;
  localparam int CC_TX    = 8;
  localparam int CC_WT_LO = 16;

  localparam logic [31:0] PCTRL_MASK = 32'h0000_0F7C;
  localparam logic [31:0] POLL_MASK  = 32'h8000_0040;
endpackage

// File: rtl/dcr_chan.sv
`timescale 1ns/1ps
module dcr_chan #(
  parameter int ST_W       = 8,
  parameter int RST_CYCLES = 4,
  localparam int CW        = $clog2(RST_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            ctrl_we,
  input  logic            stat_we,
  input  logic            ien_we,
  input  logic            wr_on,
  input  logic            wr_rst,
  input  logic            wr_tx,
  input  logic [1:0]      wr_wt,
  input  logic [ST_W-1:0] wr_bits,
  input  logic [ST_W-1:0] evt_set,
  output logic            on_q,
  output logic            tx_q,
  output logic [1:0]      wt_q,
  output logic            rst_busy,
  output logic [ST_W-1:0] stat_q,
  output logic [ST_W-1:0] ien_q
);
  logic [CW-1:0]   cnt;
  logic            done;
  logic [ST_W-1:0] clr_bits;
  logic [ST_W-1:0] set_bits;

  assign done     = rst_busy && (cnt == '0);
  assign clr_bits = stat_we ? wr_bits : '0;
  assign set_bits = rst_busy ? '0 : evt_set;

  always_ff @(posedge clk) begin
    if (clr) begin
      on_q     <= 1'b0;
      tx_q     <= 1'b0;
      wt_q     <= '0;
      rst_busy <= 1'b0;
      cnt      <= '0;
      stat_q   <= '0;
      ien_q    <= '0;
    end else begin
      if (ctrl_we) begin
        on_q <= wr_on;
        tx_q <= wr_tx;
        wt_q <= wr_wt;
      end
      if (ctrl_we && wr_rst && !rst_busy) begin
        rst_busy <= 1'b1;
        cnt      <= CW'(RST_CYCLES - 1);
      end else if (rst_busy) begin
        if (cnt == '0) rst_busy <= 1'b0;
        else           cnt      <= cnt - CW'(1);
      end
      if (done) on_q <= 1'b0;
      if (ien_we) ien_q <= wr_bits;
      if (done) stat_q <= '0;
      else      stat_q <= (stat_q & ~clr_bits) | set_bits;
    end
  end

  // R4
  rst_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (rst_busy && cnt != '0) |=> rst_busy);
  // R4
  rst_done_chk: assert property (@(posedge clk) disable iff (clr)
    done |=> (!rst_busy && !on_q && stat_q == '0));
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (clr)
    (stat_we && !rst_busy && evt_set == '0) |=> ((stat_q & $past(wr_bits)) == '0));
  // R6
  no_set_in_rst_chk: assert property (@(posedge clk) disable iff (clr)
    rst_busy |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: rtl/dcr_desc_mem.sv
`timescale 1ns/1ps
module dcr_desc_mem #(
  parameter int NUM_CH = 20,
  parameter int AW     = 5
) (
  input  logic          clk,
  input  logic          we_base,
  input  logic          we_len,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   base_q,
  output logic [31:0]   len_q
);
  logic [31:0] base_m [NUM_CH];
  logic [31:0] len_m  [NUM_CH];

  always_ff @(posedge clk) begin
    if (we_base) base_m[idx] <= wdata;
    base_q <= base_m[idx];
  end

  always_ff @(posedge clk) begin
    if (we_len) len_m[idx] <= wdata;
    len_q <= len_m[idx];
  end
endmodule

// File: rtl/dcr_port_bank.sv
`timescale 1ns/1ps
module dcr_port_bank
  import dcr_pkg::*;
#(
  parameter int NUM_PORT = 4,
  parameter int PW       = 2
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] psel,
  input  logic [31:0]   wdata,
  output logic [31:0]   rd_word
);
  logic [31:0] pc [NUM_PORT];

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (clr)                          pc[p] <= '0;
      else if (we && psel == PW'(p))    pc[p] <= wdata & PCTRL_MASK;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PORT; p++)
      if (psel == PW'(p)) rd_word = pc[p];
  end
endmodule

// File: rtl/dcr_irq.sv
`timescale 1ns/1ps
module dcr_irq #(
  parameter int NUM_CH = 20,
  parameter int ST_W   = 8
) (
  input  logic                        clk,
  input  logic                        clr,
  input  logic [NUM_CH-1:0]           gien,
  input  logic [NUM_CH-1:0][ST_W-1:0] st_v,
  input  logic [NUM_CH-1:0][ST_W-1:0] ie_v,
  output logic                        irq_q
);
  logic [NUM_CH-1:0] hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign hit[c] = gien[c] && |(st_v[c] & ie_v[c]);
  end

  always_ff @(posedge clk) begin
    if (clr) irq_q <= 1'b0;
    else     irq_q <= |hit;
  end

  // R9
  irq_needs_gien_chk: assert property (@(posedge clk) disable iff (clr)
    irq_q |-> $past(gien != '0));
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (clr)
    (gien == '0) |=> !irq_q);
endmodule

// File: rtl/dma_bank_regs.sv
`timescale 1ns/1ps
module dma_bank_regs
  import dcr_pkg::*;
#(
  parameter int NUM_CH     = 20,
  parameter int NUM_PORT   = 4,
  parameter int ST_W       = 8,
  parameter int RST_CYCLES = 4,
  parameter int HW_REV     = 3,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PW  = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic              evt_valid,
  input  logic [CHW-1:0]    evt_ch,
  input  logic [ST_W-1:0]   evt_bits,
  output logic [NUM_CH-1:0] ch_on,
  output logic [NUM_CH-1:0] ch_tx,
  output logic [NUM_CH-1:0] ch_rst,
  output logic              irq
);
  localparam logic [31:0] ID_WORD = {12'(NUM_CH), 4'(NUM_PORT), 11'b0, 5'(HW_REV)};

  logic                        soft_rst, clr;
  logic [CHW-1:0]              csel_q;
  logic [PW-1:0]               psel_q;
  logic [31:0]                 poll_q;
  logic [NUM_CH-1:0]           gien_q;
  logic                        csel_ok;
  logic                        wr_cc, wr_st, wr_ie, wr_base, wr_len;
  logic [NUM_CH-1:0][1:0]      wt_v;
  logic [NUM_CH-1:0][ST_W-1:0] st_v, ie_v;
  logic [31:0]                 sel_cc, sel_st, sel_ie;
  logic [31:0]                 port_word, base_q, len_q;
  logic [31:0]                 rd_n, rd_q;
  logic                        rvalid_q, mem_pick_q, len_pick_q;

  assign soft_rst = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
  assign clr      = rst || soft_rst;
  assign csel_ok  = (32'(csel_q) < NUM_CH);
  assign wr_cc    = reg_wr && (reg_addr == A_CCTRL) && csel_ok;
  assign wr_st    = reg_wr && (reg_addr == A_CSTAT) && csel_ok;
  assign wr_ie    = reg_wr && (reg_addr == A_CIEN)  && csel_ok;
  assign wr_base  = reg_wr && (reg_addr == A_DBASE) && csel_ok;
  assign wr_len   = reg_wr && (reg_addr == A_DLEN)  && csel_ok;

  // global registers
  always_ff @(posedge clk) begin
    if (clr) begin
      csel_q <= '0;
      psel_q <= '0;
      poll_q <= '0;
      gien_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CSEL:  csel_q <= reg_wdata[CHW-1:0];
        A_PSEL:  psel_q <= reg_wdata[PW-1:0];
        A_POLL:  poll_q <= reg_wdata & POLL_MASK;
        A_GIEN:  gien_q <= reg_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  // per-channel banks
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic            hit_sel;
    logic [ST_W-1:0] evt_set;
    assign hit_sel = (csel_q == CHW'(c));
    assign evt_set = (evt_valid && evt_ch == CHW'(c)) ? evt_bits : '0;

    dcr_chan #(.ST_W(ST_W), .RST_CYCLES(RST_CYCLES)) u_chan (
      .clk      (clk),
      .clr      (clr),
      .ctrl_we  (wr_cc && hit_sel),
      .stat_we  (wr_st && hit_sel),
      .ien_we   (wr_ie && hit_sel),
      .wr_on    (reg_wdata[CC_ON]),
      .wr_rst   (reg_wdata[CC_RST]),
      .wr_tx    (reg_wdata[CC_TX]),
      .wr_wt    (reg_wdata[CC_WT_LO+1:CC_WT_LO]),
      .wr_bits  (reg_wdata[ST_W-1:0]),
      .evt_set  (evt_set),
      .on_q     (ch_on[c]),
      .tx_q     (ch_tx[c]),
      .wt_q     (wt_v[c]),
      .rst_busy (ch_rst[c]),
      .stat_q   (st_v[c]),
      .ien_q    (ie_v[c])
    );
  end

  dcr_desc_mem #(.NUM_CH(NUM_CH), .AW(CHW)) u_desc (
    .clk     (clk),
    .we_base (wr_base),
    .we_len  (wr_len),
    .idx     (csel_q),
    .wdata   (reg_wdata),
    .base_q  (base_q),
    .len_q   (len_q)
  );

  dcr_port_bank #(.NUM_PORT(NUM_PORT), .PW(PW)) u_port (
    .clk     (clk),
    .clr     (clr),
    .we      (reg_wr && reg_addr == A_PCTRL),
    .psel    (psel_q),
    .wdata   (reg_wdata),
    .rd_word (port_word)
  );

  dcr_irq #(.NUM_CH(NUM_CH), .ST_W(ST_W)) u_irq (
    .clk   (clk),
    .clr   (clr),
    .gien  (gien_q),
    .st_v  (st_v),
    .ie_v  (ie_v),
    .irq_q (irq)
  );

  // selected channel view
  always_comb begin
    sel_cc = '0;
    sel_st = '0;
    sel_ie = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (csel_q == CHW'(c)) begin
        sel_cc = {14'b0, wt_v[c], 7'b0, ch_tx[c], 6'b0, ch_rst[c], ch_on[c]};
        sel_st = 32'(st_v[c]);
        sel_ie = 32'(ie_v[c]);
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_ID:    rd_n = ID_WORD;
      A_POLL:  rd_n = poll_q;
      A_CSEL:  rd_n = 32'(csel_q);
      A_CCTRL: rd_n = csel_ok ? sel_cc : '0;
      A_CSTAT: rd_n = csel_ok ? sel_st : '0;
      A_CIEN:  rd_n = csel_ok ? sel_ie : '0;
      A_PSEL:  rd_n = 32'(psel_q);
      A_PCTRL: rd_n = port_word;
      A_GIEN:  rd_n = 32'(gien_q);
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q   <= 1'b0;
      rd_q       <= '0;
      mem_pick_q <= 1'b0;
      len_pick_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) begin
        rd_q       <= rd_n;
        mem_pick_q <= csel_ok && (reg_addr == A_DBASE || reg_addr == A_DLEN);
        len_pick_q <= (reg_addr == A_DLEN);
      end
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = mem_pick_q ? (len_pick_q ? len_q : base_q) : rd_q;

  // R14
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  // R14
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
  // R12
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ch_on == '0 && ch_rst == '0 && !irq));
  // R13
  oob_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CCTRL && !csel_ok) |=> (ch_tx == $past(ch_tx)));
endmodule

// File: tb/dma_bank_regs_tb.sv
`timescale 1ns/1ps
module dma_bank_regs_tb;
  import dcr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_ch = '0;
  logic [7:0]  evt_bits = '0;
  logic [19:0] ch_on, ch_tx, ch_rst;
  logic        irq;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dma_bank_regs u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .evt_valid(evt_valid), .evt_ch(evt_ch), .evt_bits(evt_bits),
    .ch_on(ch_on), .ch_tx(ch_tx), .ch_rst(ch_rst), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] ch, input logic [7:0] bits);
    @(negedge clk);
    evt_valid = 1'b1; evt_ch = ch; evt_bits = bits;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  // monitor: pops expected read values as read data appears
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (sb.size() == 0) begin
        chk("R14 unexpected read data", reg_rdata, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, reg_rdata, e.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R12)
    chk("R12 irq after reset", 32'(irq), 0);
    chk("R12 ch_on after reset", 32'(ch_on), 0);
    chk("R14 rvalid idle", 32'(reg_rvalid), 0);
    rd(A_ID, 32'h0144_0003, "R1 id word");
    rd(8'h30, 32'h0, "R13 unmapped read");
    rd(A_CTRL, 32'h0, "R12 ctrl reads zero");

    // banking and control fields
    wr(A_CSEL, 32'd5);
    rd(A_CSEL, 32'd5, "R2 csel readback");
    wr(A_CCTRL, 32'hFFFF_FFFD);
    rd(A_CCTRL, 32'h0003_0101, "R3 cctrl mask");
    chk("R3 ch_on", 32'(ch_on), 32'h0000_0020);
    chk("R3 ch_tx", 32'(ch_tx), 32'h0000_0020);
    wr(A_CSEL, 32'd6);
    wr(A_CCTRL, 32'h0001_0000);
    rd(A_CCTRL, 32'h0001_0000, "R2 ch6 cctrl");
    wr(A_CSEL, 32'd5);
    rd(A_CCTRL, 32'h0003_0101, "R2 ch5 kept");

    // descriptor storage
    wr(A_DBASE, 32'hDEAD_BEE0);
    wr(A_DLEN, 32'h0000_0040);
    wr(A_CSEL, 32'd19);
    wr(A_DBASE, 32'h1234_5678);
    wr(A_DLEN, 32'h0000_0011);
    rd(A_DBASE, 32'h1234_5678, "R5 ch19 base");
    rd(A_DLEN, 32'h0000_0011, "R5 ch19 len");
    wr(A_CSEL, 32'd5);
    rd(A_DBASE, 32'hDEAD_BEE0, "R5 ch5 base");
    rd(A_DLEN, 32'h0000_0040, "R5 ch5 len");

    // out-of-range channel select
    wr(A_CSEL, 32'd20);
    wr(A_CCTRL, 32'h0000_0101);
    wr(A_DBASE, 32'hFFFF_0000);
    chk("R13 oob ch_on", 32'(ch_on), 32'h0000_0020);
    chk("R13 oob ch_tx", 32'(ch_tx), 32'h0000_0020);
    rd(A_CCTRL, 32'h0, "R13 oob cctrl read");
    rd(A_DBASE, 32'h0, "R13 oob base read");
    wr(A_CSEL, 32'd19);
    rd(A_DBASE, 32'h1234_5678, "R13 ch19 base untouched");

    // status, enables, interrupt
    wr(A_CSEL, 32'd5);
    wr(A_CIEN, 32'h0000_0008);
    rd(A_CIEN, 32'h0000_0008, "R7 cie readback");
    pulse(5'd5, 8'h08);
    repeat (2) @(negedge clk);
    chk("R9 irq needs global enable", 32'(irq), 0);
    rd(A_CSTAT, 32'h0000_0008, "R6 event sets status");
    wr(A_GIEN, 32'h0000_0020);
    chk("R9 irq one cycle lag", 32'(irq), 0);
    @(negedge clk);
    chk("R9 irq asserted", 32'(irq), 1);
    rd(A_GIEN, 32'h0000_0020, "R8 gien readback");
    wr(A_GIEN, 32'hFFFF_FFFF);
    rd(A_GIEN, 32'h000F_FFFF, "R8 gien width");
    pulse(5'd5, 8'h81);
    wr(A_CSTAT, 32'h0000_007E);
    rd(A_CSTAT, 32'h0000_0081, "R6 w1c ack");
    @(negedge clk);
    chk("R9 irq drops after ack", 32'(irq), 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CSTAT; reg_wdata = 32'h1;
    evt_valid = 1'b1; evt_ch = 5'd5; evt_bits = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    rd(A_CSTAT, 32'h0000_0081, "R6 set wins over clear");
    pulse(5'd7, 8'h08);
    pulse(5'd25, 8'hFF);
    wr(A_CSEL, 32'd7);
    rd(A_CSTAT, 32'h0000_0008, "R6 ch7 status");
    wr(A_CSEL, 32'd5);
    rd(A_CSTAT, 32'h0000_0081, "R6 ch5 unaffected");

    // channel reset
    wr(A_CCTRL, 32'h0003_0103);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R4 busy cycle %0d", k), 32'(ch_rst[5]), 1);
      if (k == 1) begin
        evt_valid = 1'b1; evt_ch = 5'd5; evt_bits = 8'h10;
      end else begin
        evt_valid = 1'b0;
      end
      @(negedge clk);
    end
    evt_valid = 1'b0;
    chk("R4 reset done", 32'(ch_rst[5]), 0);
    chk("R4 on cleared", 32'(ch_on[5]), 0);
    rd(A_CCTRL, 32'h0003_0100, "R4 dir and weight kept");
    rd(A_CSTAT, 32'h0, "R4 status cleared, event in reset dropped");
    wr(A_CCTRL, 32'h0003_0102);
    rd(A_CCTRL, 32'h0003_0102, "R4 reset bit visible");
    repeat (6) @(negedge clk);
    rd(A_CCTRL, 32'h0003_0100, "R4 reset bit self clears");

    // port bank
    wr(A_PSEL, 32'd2);
    wr(A_PCTRL, 32'hFFFF_FFFF);
    rd(A_PCTRL, 32'h0000_0F7C, "R10 pctrl mask");
    wr(A_PSEL, 32'd1);
    wr(A_PCTRL, 32'h0000_0F40);
    rd(A_PCTRL, 32'h0000_0F40, "R10 port1");
    rd(A_PSEL, 32'd1, "R10 psel readback");
    wr(A_PSEL, 32'd2);
    rd(A_PCTRL, 32'h0000_0F7C, "R10 port2 kept");

    // polling word
    wr(A_POLL, 32'hFFFF_FFFF);
    rd(A_POLL, 32'h8000_0040, "R11 poll mask");

    // engine reset
    pulse(5'd5, 8'h08);
    repeat (2) @(negedge clk);
    chk("R9 irq before engine reset", 32'(irq), 1);
    wr(A_CTRL, 32'h0000_0001);
    chk("R12 irq cleared", 32'(irq), 0);
    chk("R12 ch_tx cleared", 32'(ch_tx), 0);
    rd(A_GIEN, 32'h0, "R12 gien cleared");
    rd(A_POLL, 32'h0, "R12 poll cleared");
    rd(A_CSEL, 32'h0, "R12 csel cleared");
    rd(A_PSEL, 32'h0, "R12 psel cleared");
    wr(A_PSEL, 32'd2);
    rd(A_PCTRL, 32'h0, "R12 port word cleared");
    wr(A_CSEL, 32'd5);
    rd(A_CSTAT, 32'h0, "R12 status cleared");
    wr(A_CSEL, 32'd19);
    rd(A_DBASE, 32'h1234_5678, "R12 descriptor kept");

    repeat (4) @(negedge clk);
    chk("R14 all reads answered", 32'(sb.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule